// File: doc/BRIEF.md
# SIMT Load-Store Request Tracker

This block sits between the issue queue and the memory system of a core that runs N threads in lockstep. Each incoming vector memory instruction carries one address per thread, an active-thread mask, an operation code and an instruction identifier. For a load, the block claims a slot in a small pending table and sends one request per active thread. When thread 0 is active and every active thread targets the same memory word, it sends a single request instead. The slot records how many responses are still owed. Responses come back tagged with the slot number, on any per-thread port. When the count of a slot runs out, the instruction retires on a one-per-cycle output and the slot is freed.

Each request is steered by address. Requests to the shared region go to a per-thread shared-memory port. All other requests go to the data-cache port, with a non-cacheable flag raised for the I/O region. Stores do not wait for responses: they retire as soon as they issue, through a short store queue when the output is busy. A fence stops the input until every outstanding load and queued store has retired, and then retires itself.

Top module: `simt_lsu_tracker`

## Requirements
- R1: A load (op 2'b00, and the unused code 2'b11 is treated as a load) that is accepted claims the lowest-numbered free slot of the DEPTH-entry table, and every request it sends carries that slot number on `req_tag`.
- R2: Each valid response whose tag names a slot lowers that slot's remaining count by one. When the count reaches zero, the instruction's identifier appears on `out_id` with `out_valid` high, and the slot becomes free for a later load.
- R3: While all DEPTH slots are in use, `in_ready` is low for loads and stores, no request is sent and the instruction is not consumed.
- R4: If thread 0 is active and all active addresses agree once the low log2(WORD_BYTES) byte-offset bits are ignored, only thread 0 sends a request, and one response retires the load. Otherwise each active thread sends one request.
- R5: A request address whose top byte is 8'hFF (shared region) raises `sm_req_valid` for its thread and not `dc_req_valid`. Any other address uses `dc_req_valid`, and `req_nc` is set for that thread only when the top byte is 8'hF0 (I/O region).
- R6: A store (op 2'b01) sends its requests with `req_write` high and retires without any response. It does not occupy a table slot, so the next load gets the same slot it would have got anyway.
- R7: A fence (op 2'b10) is consumed at once and holds `in_ready` low afterwards. Its identifier is retired only after every earlier load and store has retired, and `in_ready` rises again after that.
- R8: Responses arriving in the same cycle on any mix of data-cache and shared-memory ports, for one slot or several, are all counted.
- R9: At most one instruction retires per cycle. Completed loads go before stores, lower slot numbers go before higher ones, and a store that cannot retire at once retires in a later cycle, in order.
- R10: A load with an all-zero mask sends no request and retires without any response.
- R11: Each request drives `req_addr` for its thread with that thread's input address, and `req_core` with the CORE_ID parameter.
- R12: After reset, `out_valid` and all request valids are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction presented |
| in_ready | output | 1 | Instruction consumed this cycle when high together with in_valid |
| in_op | input | 2 | 00 load, 01 store, 10 fence, 11 treated as load |
| in_mask | input | NT | Active-thread mask |
| in_addr | input | NT*ADDR_W | Per-thread addresses, thread t at bits t*ADDR_W |
| in_id | input | ID_W | Instruction identifier returned on retirement |
| dc_req_valid | output | NT | Per-thread data-cache request |
| sm_req_valid | output | NT | Per-thread shared-memory request |
| req_addr | output | NT*ADDR_W | Per-thread request address |
| req_nc | output | NT | Per-thread non-cacheable flag |
| req_write | output | 1 | Requests belong to a store |
| req_tag | output | TAG_W | Slot number carried by the requests |
| req_core | output | CORE_W | Core identifier |
| dc_rsp_valid | input | NT | Per-thread data-cache response |
| dc_rsp_tag | input | NT*TAG_W | Tags of the data-cache responses |
| sm_rsp_valid | input | NT | Per-thread shared-memory response |
| sm_rsp_tag | input | NT*TAG_W | Tags of the shared-memory responses |
| out_valid | output | 1 | An instruction retires |
| out_id | output | ID_W | Identifier of the retiring instruction |

## Verification
The assertions assume that the memory side never returns more responses for a slot than that slot still owes, and never returns a response for a free slot. They also assume that request ports always accept, since the block has no back-pressure on them. The bench keeps within these rules: it answers only the requests it captured, once each, using the tag it saw on `req_tag`. Input signals change only between clock edges.

// File: rtl/lsu_trk_pkg.sv
// Shared definitions for the load-store request tracker.
// Assumes: the op code is two bits wide and its values are fixed by the issue stage.
package lsu_trk_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_FENCE = 2'b10,
        OP_RSVD  = 2'b11
    } lsu_op_e;
endpackage

// File: rtl/lsu_region_decode.sv
// Classifies one address into shared, I/O or plain cacheable space.
// Assumes: the shared and I/O windows do not overlap; shared wins if they do.
module lsu_region_decode #(
    parameter int              ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] SHARED_BASE = 32'hFF00_0000,
    parameter logic [ADDR_W-1:0] SHARED_MASK = 32'hFF00_0000,
    parameter logic [ADDR_W-1:0] IO_BASE     = 32'hF000_0000,
    parameter logic [ADDR_W-1:0] IO_MASK     = 32'hFF00_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_shared,
    output logic              is_io
);
    // Window compare for both regions.
    always_comb begin
        is_shared = ((addr & SHARED_MASK) == SHARED_BASE);
        is_io     = ((addr & IO_MASK) == IO_BASE) && !is_shared;
    end
endmodule

// File: rtl/lsu_merge_detect.sv
// Decides whether all active threads of an instruction touch one word and
// computes the number of responses the instruction will be owed.
// Assumes: WORD_BYTES is a power of two.
module lsu_merge_detect #(
    parameter int NT         = 4,
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4,
    parameter int CNT_W      = $clog2(NT + 1)
) (
    input  logic [NT-1:0]        mask,
    input  logic [NT*ADDR_W-1:0] addr_flat,
    output logic                 merge,
    output logic [CNT_W-1:0]     expect_cnt
);
    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(WORD_BYTES - 1);

    logic [ADDR_W-1:0] word0;
    logic              all_same;
    logic [CNT_W-1:0]  active_cnt;

    // Compare every active thread's word address with thread 0's and count actives.
    always_comb begin
        word0      = addr_flat[ADDR_W-1:0] & ~OFF_MASK;
        all_same   = 1'b1;
        active_cnt = '0;
        for (int t = 0; t < NT; t++) begin
            if (mask[t]) begin
                active_cnt = active_cnt + CNT_W'(1);
                if ((addr_flat[t*ADDR_W +: ADDR_W] & ~OFF_MASK) != word0) begin
                    all_same = 1'b0;
                end
            end
        end
        merge      = mask[0] && all_same;
        expect_cnt = merge ? CNT_W'(1) : active_cnt;
    end
endmodule

// File: rtl/lsu_pending_table.sv
// Table of outstanding loads. Each slot holds the instruction identifier, the
// number of responses still owed and a completed flag. Slots are claimed at the
// lowest free index and released when their completion is sent to the output.
// Assumes: responses never exceed the count still owed and never name a free slot.
module lsu_pending_table #(
    parameter int NT    = 4,
    parameter int DEPTH = 4,
    parameter int ID_W  = 8,
    parameter int TAG_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(NT + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_en,
    input  logic [CNT_W-1:0]    alloc_cnt,
    input  logic [ID_W-1:0]     alloc_id,
    input  logic [NT-1:0]       dc_rsp_valid,
    input  logic [NT*TAG_W-1:0] dc_rsp_tag,
    input  logic [NT-1:0]       sm_rsp_valid,
    input  logic [NT*TAG_W-1:0] sm_rsp_tag,
    input  logic                release_en,
    output logic [DEPTH-1:0]    vld_o,
    output logic [TAG_W-1:0]    free_tag,
    output logic                done_any,
    output logic [TAG_W-1:0]    done_tag,
    output logic [ID_W-1:0]     done_id
);
    localparam int RSP_W = $clog2(2 * NT + 1);

    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] done_q;
    logic [CNT_W-1:0] cnt_q [DEPTH];
    logic [ID_W-1:0]  id_q  [DEPTH];
    logic [RSP_W-1:0] dec   [DEPTH];
    logic [RSP_W-1:0] left  [DEPTH];

    // Count this cycle's responses per slot over both port groups.
    always_comb begin
        for (int e = 0; e < DEPTH; e++) begin
            dec[e] = '0;
            for (int t = 0; t < NT; t++) begin
                if (dc_rsp_valid[t] && dc_rsp_tag[t*TAG_W +: TAG_W] == TAG_W'(e)) begin
                    dec[e] = dec[e] + RSP_W'(1);
                end
                if (sm_rsp_valid[t] && sm_rsp_tag[t*TAG_W +: TAG_W] == TAG_W'(e)) begin
                    dec[e] = dec[e] + RSP_W'(1);
                end
            end
            left[e] = RSP_W'(cnt_q[e]) - dec[e];
        end
    end

    // Pick the lowest free slot and the lowest completed slot.
    always_comb begin
        free_tag = '0;
        done_tag = '0;
        done_any = 1'b0;
        for (int e = DEPTH - 1; e >= 0; e--) begin
            if (!vld_q[e]) begin
                free_tag = TAG_W'(e);
            end
            if (done_q[e]) begin
                done_tag = TAG_W'(e);
                done_any = 1'b1;
            end
        end
        done_id = id_q[done_tag];
        vld_o   = vld_q;
    end

    // Slot state: claim, release, or count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            done_q <= '0;
            for (int e = 0; e < DEPTH; e++) begin
                cnt_q[e] <= '0;
                id_q[e]  <= '0;
            end
        end else begin
            for (int e = 0; e < DEPTH; e++) begin
                if (alloc_en && free_tag == TAG_W'(e)) begin
                    vld_q[e]  <= 1'b1;
                    done_q[e] <= (alloc_cnt == '0);
                    cnt_q[e]  <= alloc_cnt;
                    id_q[e]   <= alloc_id;
                end else if (release_en && done_tag == TAG_W'(e)) begin
                    vld_q[e]  <= 1'b0;
                    done_q[e] <= 1'b0;
                end else if (vld_q[e] && !done_q[e] && dec[e] != '0) begin
                    cnt_q[e] <= CNT_W'(left[e]);
                    if (left[e] == '0) begin
                        done_q[e] <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/lsu_store_queue.sv
// Small in-order queue of store identifiers waiting for a free output cycle.
// Assumes: push is never requested while full (the caller gates acceptance).
module lsu_store_queue #(
    parameter int ID_W  = 8,
    parameter int DEPTH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [ID_W-1:0] push_id,
    input  logic            pop,
    output logic [ID_W-1:0] head_id,
    output logic            empty,
    output logic            full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ID_W-1:0]  mem_q [DEPTH];
    logic [PTR_W-1:0] rd_q;
    logic [PTR_W-1:0] wr_q;
    logic [CNT_W-1:0] cnt_q;

    // Status flags from the occupancy count.
    always_comb begin
        empty   = (cnt_q == '0);
        full    = (cnt_q == CNT_W'(DEPTH));
        head_id = mem_q[rd_q];
    end

    // Pointer and storage update with explicit wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            if (push) begin
                mem_q[wr_q] <= push_id;
                wr_q        <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + PTR_W'(1);
            end
            if (pop) begin
                rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + PTR_W'(1);
            end
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end
endmodule

// File: rtl/simt_lsu_tracker.sv
// Top of the load-store request tracker. Accepts one vector memory instruction
// per cycle, fans it out into per-thread requests routed by address region,
// tracks outstanding loads in a pending table, retires one instruction per
// cycle and implements a draining fence.
// Assumes: request ports always accept; responses obey the table's rules.
module simt_lsu_tracker #(
    parameter int                NT          = 4,
    parameter int                ADDR_W      = 32,
    parameter int                ID_W        = 8,
    parameter int                DEPTH       = 4,
    parameter int                SQ_DEPTH    = 2,
    parameter int                WORD_BYTES  = 4,
    parameter int                CORE_W      = 4,
    parameter logic [CORE_W-1:0] CORE_ID     = 4'h3,
    parameter logic [ADDR_W-1:0] SHARED_BASE = 32'hFF00_0000,
    parameter logic [ADDR_W-1:0] SHARED_MASK = 32'hFF00_0000,
    parameter logic [ADDR_W-1:0] IO_BASE     = 32'hF000_0000,
    parameter logic [ADDR_W-1:0] IO_MASK     = 32'hFF00_0000,
    parameter int                TAG_W       = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [1:0]           in_op,
    input  logic [NT-1:0]        in_mask,
    input  logic [NT*ADDR_W-1:0] in_addr,
    input  logic [ID_W-1:0]      in_id,
    output logic [NT-1:0]        dc_req_valid,
    output logic [NT-1:0]        sm_req_valid,
    output logic [NT*ADDR_W-1:0] req_addr,
    output logic [NT-1:0]        req_nc,
    output logic                 req_write,
    output logic [TAG_W-1:0]     req_tag,
    output logic [CORE_W-1:0]    req_core,
    input  logic [NT-1:0]        dc_rsp_valid,
    input  logic [NT*TAG_W-1:0]  dc_rsp_tag,
    input  logic [NT-1:0]        sm_rsp_valid,
    input  logic [NT*TAG_W-1:0]  sm_rsp_tag,
    output logic                 out_valid,
    output logic [ID_W-1:0]      out_id
);
    import lsu_trk_pkg::*;

    localparam int CNT_W = $clog2(NT + 1);

    logic             is_fence;
    logic             is_store;
    logic             in_fire;
    logic             fence_fire;
    logic             store_fire;
    logic             load_fire;
    logic             merge;
    logic [CNT_W-1:0] expect_cnt;
    logic [DEPTH-1:0] tbl_vld;
    logic             tbl_full;
    logic             tbl_empty;
    logic [TAG_W-1:0] free_tag;
    logic             done_any;
    logic [TAG_W-1:0] done_tag;
    logic [ID_W-1:0]  done_id;
    logic             release_en;
    logic             sq_push;
    logic             sq_pop;
    logic [ID_W-1:0]  sq_head;
    logic             sq_empty;
    logic             sq_full;
    logic             lock_q;
    logic [ID_W-1:0]  fence_id_q;
    logic             fence_done;
    logic             nxt_valid;
    logic [ID_W-1:0]  nxt_id;

    // Input decode and acceptance.
    always_comb begin
        is_fence   = (in_op == OP_FENCE);
        is_store   = (in_op == OP_STORE);
        tbl_full   = &tbl_vld;
        tbl_empty  = ~|tbl_vld;
        in_ready   = !lock_q && (is_fence || (!tbl_full && (!is_store || !sq_full)));
        in_fire    = in_valid && in_ready;
        fence_fire = in_fire && is_fence;
        store_fire = in_fire && is_store;
        load_fire  = in_fire && !is_fence && !is_store;
    end

    lsu_merge_detect #(
        .NT(NT), .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .CNT_W(CNT_W)
    ) u_merge (
        .mask(in_mask), .addr_flat(in_addr), .merge(merge), .expect_cnt(expect_cnt)
    );

    // Per-thread request fan-out with region steering.
    for (genvar t = 0; t < NT; t++) begin : g_lane
        logic lane_shared;
        logic lane_io;
        logic lane_act;

        lsu_region_decode #(
            .ADDR_W(ADDR_W), .SHARED_BASE(SHARED_BASE), .SHARED_MASK(SHARED_MASK),
            .IO_BASE(IO_BASE), .IO_MASK(IO_MASK)
        ) u_region (
            .addr(in_addr[t*ADDR_W +: ADDR_W]), .is_shared(lane_shared), .is_io(lane_io)
        );

        // Lane fires when its thread is active and not folded into thread 0.
        always_comb begin
            lane_act        = in_fire && !is_fence && in_mask[t] && (!merge || t == 0);
            dc_req_valid[t] = lane_act && !lane_shared;
            sm_req_valid[t] = lane_act && lane_shared;
            req_nc[t]       = lane_io;
        end
    end

    // Fields shared by all lanes.
    always_comb begin
        req_addr  = in_addr;
        req_write = is_store;
        req_tag   = free_tag;
        req_core  = CORE_ID;
    end

    lsu_pending_table #(
        .NT(NT), .DEPTH(DEPTH), .ID_W(ID_W), .TAG_W(TAG_W), .CNT_W(CNT_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(load_fire), .alloc_cnt(expect_cnt), .alloc_id(in_id),
        .dc_rsp_valid(dc_rsp_valid), .dc_rsp_tag(dc_rsp_tag),
        .sm_rsp_valid(sm_rsp_valid), .sm_rsp_tag(sm_rsp_tag),
        .release_en(release_en), .vld_o(tbl_vld), .free_tag(free_tag),
        .done_any(done_any), .done_tag(done_tag), .done_id(done_id)
    );

    lsu_store_queue #(
        .ID_W(ID_W), .DEPTH(SQ_DEPTH)
    ) u_sq (
        .clk(clk), .rst_n(rst_n), .push(sq_push), .push_id(in_id), .pop(sq_pop),
        .head_id(sq_head), .empty(sq_empty), .full(sq_full)
    );

    // Output arbitration: completed loads, queued stores, a fresh store, then the fence.
    always_comb begin
        release_en = 1'b0;
        sq_pop     = 1'b0;
        fence_done = 1'b0;
        nxt_valid  = 1'b0;
        nxt_id     = '0;
        if (done_any) begin
            release_en = 1'b1;
            nxt_valid  = 1'b1;
            nxt_id     = done_id;
        end else if (!sq_empty) begin
            sq_pop    = 1'b1;
            nxt_valid = 1'b1;
            nxt_id    = sq_head;
        end else if (store_fire) begin
            nxt_valid = 1'b1;
            nxt_id    = in_id;
        end else if (lock_q && tbl_empty) begin
            fence_done = 1'b1;
            nxt_valid  = 1'b1;
            nxt_id     = fence_id_q;
        end
        sq_push = store_fire && (done_any || !sq_empty);
    end

    // Fence lock and registered output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q     <= 1'b0;
            fence_id_q <= '0;
            out_valid  <= 1'b0;
            out_id     <= '0;
        end else begin
            if (fence_fire) begin
                lock_q     <= 1'b1;
                fence_id_q <= in_id;
            end else if (fence_done) begin
                lock_q <= 1'b0;
            end
            out_valid <= nxt_valid;
            out_id    <= nxt_id;
        end
    end
endmodule

// File: rtl/simt_lsu_tracker_checker.sv
// Protocol checks for the load-store request tracker, attached with bind.
// Assumes: inputs obey the response rules stated for the pending table.
module simt_lsu_tracker_checker #(
    parameter int NT    = 4,
    parameter int DEPTH = 4,
    parameter int TAG_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [1:0]       in_op,
    input logic [NT-1:0]    in_mask,
    input logic [NT-1:0]    dc_req_valid,
    input logic [NT-1:0]    sm_req_valid,
    input logic [TAG_W-1:0] req_tag,
    input logic [DEPTH-1:0] tbl_vld
);
    logic fire;
    logic fire_load;
    assign fire      = in_valid && in_ready;
    assign fire_load = fire && in_op != 2'b01 && in_op != 2'b10;

    // R1: a new load never lands on a slot in use
    assert_alloc_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fire_load |-> !tbl_vld[req_tag]);

    // R3: a full table stalls loads and stores
    assert_stall_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((&tbl_vld) && in_op != 2'b10) |-> !in_ready);

    // R4: no requests without acceptance, never more than active threads
    assert_no_stray_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |-> ((dc_req_valid | sm_req_valid) == '0));
    assert_req_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> ($countones(dc_req_valid | sm_req_valid) <= $countones(in_mask)));

    // R5: one lane never uses both ports
    assert_port_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_req_valid & sm_req_valid) == '0);

    // R7: accepting a fence closes the input next cycle
    assert_fence_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && in_op == 2'b10) |=> !in_ready);
endmodule

bind simt_lsu_tracker simt_lsu_tracker_checker #(
    .NT(NT), .DEPTH(DEPTH), .TAG_W(TAG_W)
) i_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_mask(in_mask), .dc_req_valid(dc_req_valid),
    .sm_req_valid(sm_req_valid), .req_tag(req_tag), .tbl_vld(tbl_vld)
);

// File: tb/test_simt_lsu_tracker.sv
`timescale 1ns/1ps
module test_simt_lsu_tracker;
    localparam int NT = 4;
    localparam int AW = 32;
    localparam int IDW = 8;
    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [1:0]    in_op = 2'b00;
    logic [NT-1:0] in_mask = '0;
    logic [NT*AW-1:0] in_addr = '0;
    logic [IDW-1:0] in_id = '0;
    logic [NT-1:0] dc_req_valid, sm_req_valid, req_nc;
    logic [NT*AW-1:0] req_addr;
    logic          req_write;
    logic [TW-1:0] req_tag;
    logic [3:0]    req_core;
    logic [NT-1:0] dc_rsp_valid = '0, sm_rsp_valid = '0;
    logic [NT*TW-1:0] dc_rsp_tag = '0, sm_rsp_tag = '0;
    logic          out_valid;
    logic [IDW-1:0] out_id;

    always #2.5 clk = ~clk;

    simt_lsu_tracker i_simt_lsu_tracker (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_mask(in_mask), .in_addr(in_addr), .in_id(in_id),
        .dc_req_valid(dc_req_valid), .sm_req_valid(sm_req_valid), .req_addr(req_addr),
        .req_nc(req_nc), .req_write(req_write), .req_tag(req_tag), .req_core(req_core),
        .dc_rsp_valid(dc_rsp_valid), .dc_rsp_tag(dc_rsp_tag),
        .sm_rsp_valid(sm_rsp_valid), .sm_rsp_tag(sm_rsp_tag),
        .out_valid(out_valid), .out_id(out_id)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Retirement log, filled away from the active edge.
    logic [IDW-1:0] log_id [0:255];
    int log_cyc [0:255];
    int log_n = 0;
    always @(negedge clk) begin
        if (rst_n && out_valid && log_n < 256) begin
            log_id[log_n]  <= out_id;
            log_cyc[log_n] <= cyc;
            log_n          <= log_n + 1;
        end
    end

    logic [AW-1:0] a [NT];
    logic [NT-1:0] cap_dc, cap_sm, cap_nc;
    logic          cap_write;
    logic [TW-1:0] cap_tag;
    logic [NT*AW-1:0] cap_addr;
    logic [3:0]    cap_core;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int pop4(input logic [3:0] m);
        return int'(m[0]) + int'(m[1]) + int'(m[2]) + int'(m[3]);
    endfunction

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Present one instruction, wait for acceptance, capture the requests.
    task automatic issue(input logic [1:0] op, input logic [3:0] m, input logic [7:0] id);
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_op    = op;
        in_mask  = m;
        in_id    = id;
        in_addr  = {a[3], a[2], a[1], a[0]};
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        cap_dc    = dc_req_valid;
        cap_sm    = sm_req_valid;
        cap_nc    = req_nc;
        cap_write = req_write;
        cap_tag   = req_tag;
        cap_addr  = req_addr;
        cap_core  = req_core;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_mask  = '0;
    endtask

    // Drive one cycle of responses.
    task automatic rsp(input logic [3:0] dthr, input logic [7:0] dtags,
                       input logic [3:0] sthr, input logic [7:0] stags);
        dc_rsp_valid = dthr;
        dc_rsp_tag   = dtags;
        sm_rsp_valid = sthr;
        sm_rsp_tag   = stags;
        @(posedge clk);
        #1;
        dc_rsp_valid = '0;
        sm_rsp_valid = '0;
    endtask

    // Answer the captured requests one per cycle and check the single retirement.
    task automatic answer_all(input string req, input logic [7:0] id);
        int base;
        int total;
        int sent;
        base  = log_n;
        total = pop4(cap_dc) + pop4(cap_sm);
        sent  = 0;
        for (int t = 0; t < NT; t++) begin
            if (cap_dc[t] || cap_sm[t]) begin
                sent++;
                if (sent == total) chk(req, "no retire before last response", log_n - base, 0);
                rsp(cap_dc[t] ? 4'(1 << t) : 4'b0, {4{cap_tag}},
                    cap_sm[t] ? 4'(1 << t) : 4'b0, {4{cap_tag}});
            end
        end
        idle(2);
        chk(req, "retire count", log_n - base, 1);
        if (log_n > base) chk(req, "retired id", int'(log_id[base]), int'(id));
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base;
        for (int t = 0; t < NT; t++) a[t] = '0;
        idle(4);
        @(negedge clk);
        // R12 reset state
        chk("R12", "out_valid", int'(out_valid), 0);
        chk("R12", "in_ready", int'(in_ready), 1);
        chk("R12", "request valids", int'(dc_req_valid | sm_req_valid), 0);
        rst_n = 1'b1;
        idle(2);

        // R1 R2 R10 R11: all masks, distinct words
        for (int m = 0; m < 16; m++) begin
            for (int t = 0; t < NT; t++) a[t] = 32'h1000 + 32'(t * 64) + 32'(m * 1024);
            issue(2'b00, 4'(m), 8'(m));
            chk("R4", "request count distinct", pop4(cap_dc), pop4(4'(m)));
            chk("R5", "no shared requests", int'(cap_sm), 0);
            chk("R1", "slot in empty table", int'(cap_tag), 0);
            if (m[3]) chk("R11", "thread 3 address", int'(cap_addr[3*AW +: AW] == a[3]), 1);
            chk("R11", "core id", int'(cap_core), 3);
            chk("R6", "load write flag", int'(cap_write), 0);
            answer_all(m == 0 ? "R10" : "R2", 8'(m));
        end

        // R4: all masks, same word with different byte offsets
        for (int m = 0; m < 16; m++) begin
            for (int t = 0; t < NT; t++) a[t] = 32'h2000 + 32'(t);
            issue(2'b00, 4'(m), 8'(32 + m));
            if (m[0]) chk("R4", "merged to thread 0", int'(cap_dc), 1);
            else chk("R4", "unmerged count", pop4(cap_dc), pop4(4'(m)));
            answer_all("R4", 8'(32 + m));
        end

        // R5 R8: routing and simultaneous responses on both port groups
        a[0] = 32'hFF00_0010; a[1] = 32'hF000_0020; a[2] = 32'h0000_3000; a[3] = 32'hFF00_0040;
        issue(2'b00, 4'b1111, 8'd50);
        chk("R5", "shared lanes", int'(cap_sm), 9);
        chk("R5", "cache lanes", int'(cap_dc), 6);
        chk("R5", "io lane non-cacheable", int'(cap_nc[1]), 1);
        chk("R5", "plain lane cacheable", int'(cap_nc[2]), 0);
        base = log_n;
        rsp(cap_dc, {4{cap_tag}}, cap_sm, {4{cap_tag}});
        idle(2);
        chk("R8", "retire after one response cycle", log_n - base, 1);
        if (log_n > base) chk("R8", "retired id", int'(log_id[base]), 50);

        // R6: store retires with no responses, holds no slot
        for (int t = 0; t < NT; t++) a[t] = 32'h4000 + 32'(t * 16);
        base = log_n;
        issue(2'b01, 4'b0011, 8'd55);
        chk("R6", "store write flag", int'(cap_write), 1);
        chk("R6", "store requests", int'(cap_dc), 3);
        idle(1);
        chk("R6", "store retired", log_n - base, 1);
        if (log_n > base) chk("R6", "store id", int'(log_id[base]), 55);
        issue(2'b00, 4'b0001, 8'd56);
        chk("R6", "slot not held by store", int'(cap_tag), 0);
        answer_all("R2", 8'd56);

        // R1 R3: fill the table then stall
        for (int i = 0; i < 4; i++) begin
            issue(2'b00, 4'b0001, 8'(40 + i));
            chk("R1", "lowest free slot", int'(cap_tag), i);
        end
        in_valid = 1'b1; in_op = 2'b00; in_mask = 4'b0001; in_id = 8'd44;
        idle(2);
        @(negedge clk);
        chk("R3", "load stalled", int'(in_ready), 0);
        chk("R3", "no request while full", int'(dc_req_valid | sm_req_valid), 0);
        in_op = 2'b01;
        @(negedge clk);
        chk("R3", "store stalled", int'(in_ready), 0);
        #1;
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        base = log_n;
        rsp(4'b0001, {4{2'd2}}, 4'b0, 8'h0);
        idle(2);
        chk("R2", "slot 2 retired", log_n - base, 1);
        if (log_n > base) chk("R2", "slot 2 id", int'(log_id[base]), 42);
        issue(2'b00, 4'b0001, 8'd44);
        chk("R2", "freed slot reused", int'(cap_tag), 2);
        rsp(4'b0001, {4{2'd0}}, 4'b0, 8'h0);
        rsp(4'b0001, {4{2'd1}}, 4'b0, 8'h0);
        rsp(4'b0001, {4{2'd3}}, 4'b0, 8'h0);
        rsp(4'b0001, {4{2'd2}}, 4'b0, 8'h0);
        idle(4);

        // R9: two loads complete together, lower slot first
        for (int t = 0; t < NT; t++) a[t] = 32'h5000 + 32'(t * 16);
        issue(2'b00, 4'b0001, 8'd80);
        issue(2'b00, 4'b0010, 8'd81);
        base = log_n;
        rsp(4'b0011, {2'd0, 2'd0, 2'd1, 2'd0}, 4'b0, 8'h0);
        idle(3);
        chk("R9", "two retirements", log_n - base, 2);
        if (log_n > base + 1) begin
            chk("R9", "lower slot first", int'(log_id[base]), 80);
            chk("R9", "higher slot next", int'(log_id[base + 1]), 81);
            chk("R9", "one per cycle", log_cyc[base + 1] - log_cyc[base], 1);
        end

        // R9: completed load beats a store issuing in the same cycle
        issue(2'b00, 4'b0001, 8'd60);
        base = log_n;
        dc_rsp_valid = 4'b0001; dc_rsp_tag = {4{cap_tag}};
        @(posedge clk);
        #1;
        dc_rsp_valid = '0;
        in_valid = 1'b1; in_op = 2'b01; in_mask = 4'b0001; in_id = 8'd61;
        @(negedge clk);
        chk("R9", "store accepted during collision", int'(in_ready), 1);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        idle(3);
        chk("R9", "collision retirements", log_n - base, 2);
        if (log_n > base + 1) begin
            chk("R9", "load before store", int'(log_id[base]), 60);
            chk("R9", "store after load", int'(log_id[base + 1]), 61);
            chk("R9", "consecutive cycles", log_cyc[base + 1] - log_cyc[base], 1);
        end

        // R7: fence waits for the outstanding load
        issue(2'b00, 4'b0001, 8'd70);
        base = log_n;
        issue(2'b10, 4'b0000, 8'd71);
        in_valid = 1'b1; in_op = 2'b00; in_mask = 4'b0001; in_id = 8'd72;
        idle(3);
        @(negedge clk);
        chk("R7", "input closed by fence", int'(in_ready), 0);
        chk("R7", "fence not retired early", log_n - base, 0);
        #1;
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        rsp(4'b0001, {4{2'd0}}, 4'b0, 8'h0);
        idle(4);
        chk("R7", "load and fence retired", log_n - base, 2);
        if (log_n > base + 1) begin
            chk("R7", "load first", int'(log_id[base]), 70);
            chk("R7", "fence last", int'(log_id[base + 1]), 71);
        end
        in_op = 2'b00;
        @(negedge clk);
        chk("R7", "input reopened", int'(in_ready), 1);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule